// File: doc/BRIEF.md
# Self-Widening Clock Accuracy Bounds

This block keeps the two halves of the uncertainty interval that goes with a local clock. One register bounds how far real time may lie behind the clock, and the other bounds how far it may lie ahead. After a synchronization round, software writes fresh values into both. From then on, each half grows by its own programmed increment on every oscillator tick. The interval therefore widens by itself at the assumed drift rate until the next correction.

Each half is a saturating adder. When an increment would carry past the largest representable value, the half sticks at that value and raises a sticky flag. Only a new load clears the flag. A snapshot strobe latches the time value from the local clock together with both halves in the same cycle, so a packet stamp always carries a consistent time and interval.

Top module: `acc_interval_unit`

## Requirements
- R1: After reset, both bounds read the all-ones value 2^ACC_W-1 and both saturation flags read 1. Both increments are zero, and snap_valid_o and all snapshot outputs are zero.
- R2: A load strobe for a bound in cycle k makes that bound equal load_val_i from cycle k+1 and clears its saturation flag. A load overrides a tick in the same cycle.
- R3: A tick with no load in cycle k makes each bound equal its cycle-k value plus its cycle-k increment in cycle k+1, as long as that sum is at most 2^ACC_W-1. A sum of exactly 2^ACC_W-1 leaves the flag unchanged.
- R4: The two bounds are independent. Each bound uses only its own increment and its own load strobe, and strobing one leaves the other unchanged.
- R5: If bound plus increment exceeds 2^ACC_W-1 on a tick, the bound becomes 2^ACC_W-1 and its flag becomes 1. The flag then stays 1 until that bound is loaded.
- R6: An increment write in cycle k takes effect from the first tick in cycle k+1. A tick in cycle k itself still uses the old increment.
- R7: In a cycle with neither tick nor load, both bounds and both flags hold their values.
- R8: A snapshot strobe in cycle k raises snap_valid_o for exactly cycle k+1. The snapshot outputs then show time_i and both bounds as they were in cycle k, before any update in that cycle. They hold until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Oscillator tick enable |
| load_neg_i | input | 1 | Load the lower bound from load_val_i |
| load_pos_i | input | 1 | Load the upper bound from load_val_i |
| load_val_i | input | ACC_W | Value for a bound load |
| step_neg_wr_i | input | 1 | Write the lower-bound increment |
| step_pos_wr_i | input | 1 | Write the upper-bound increment |
| step_val_i | input | STEP_W | Value for an increment write |
| snap_i | input | 1 | Snapshot strobe |
| time_i | input | TIME_W | Local clock value to capture |
| neg_bound_o | output | ACC_W | Current lower bound |
| pos_bound_o | output | ACC_W | Current upper bound |
| neg_sat_o | output | 1 | Sticky saturation flag, lower bound |
| pos_sat_o | output | 1 | Sticky saturation flag, upper bound |
| snap_valid_o | output | 1 | One-cycle pulse after a snapshot strobe |
| snap_time_o | output | TIME_W | Captured time value |
| snap_neg_o | output | ACC_W | Captured lower bound |
| snap_pos_o | output | ACC_W | Captured upper bound |

## Verification
The assertions assume that the increment is narrower than or equal to the bound width. They also assume that every strobe is a clean single-cycle level sampled at the clock edge, and that a load and a tick may coincide. The stimulus drives all inputs on the falling edge only. It deliberately places loads and increment writes in the same cycle as ticks, and it steers one bound to land exactly on the maximum and the other to carry past it. The saturation and priority assertions therefore see their trigger conditions without any input outside those assumptions.

// File: rtl/acc_pkg.sv
package acc_pkg;
   localparam int NUM_BOUNDS = 2;

   typedef enum int {
      BND_NEG = 0,
      BND_POS = 1
   } bnd_idx_e;
endpackage

// File: rtl/acc_step_reg.sv
module acc_step_reg #(
   parameter int STEP_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [STEP_W-1:0] val_i,
   output logic [STEP_W-1:0] step_o
);
   logic [STEP_W-1:0] step_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= '0;
      end else if (wr_i) begin
         step_q <= val_i;
      end
   end

   assign step_o = step_q;

   AST_STEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |=> $stable(step_o)); // R6
endmodule

// File: rtl/acc_bound_adder.sv
module acc_bound_adder #(
   parameter int ACC_W  = 24,
   parameter int STEP_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              load_i,
   input  logic [ACC_W-1:0]  load_val_i,
   input  logic [STEP_W-1:0] step_i,
   output logic [ACC_W-1:0]  bound_o,
   output logic              sat_o
);
   localparam int SUM_W = ACC_W + 1;
   localparam logic [ACC_W-1:0] BND_MAX = {ACC_W{1'b1}};

   logic [ACC_W-1:0] bnd_q, bnd_d;
   logic             sat_q, sat_d;
   logic [SUM_W-1:0] sum_w;
   logic             carry_w;

   assign sum_w   = {1'b0, bnd_q} + {{(SUM_W-STEP_W){1'b0}}, step_i};
   assign carry_w = sum_w[ACC_W];

   always_comb begin
      bnd_d = bnd_q;
      sat_d = sat_q;
      if (load_i) begin
         bnd_d = load_val_i;
         sat_d = 1'b0;
      end else if (tick_i) begin
         if (carry_w) begin
            bnd_d = BND_MAX;
            sat_d = 1'b1;
         end else begin
            bnd_d = sum_w[ACC_W-1:0];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bnd_q <= BND_MAX;
         sat_q <= 1'b1;
      end else begin
         bnd_q <= bnd_d;
         sat_q <= sat_d;
      end
   end

   assign bound_o = bnd_q;
   assign sat_o   = sat_q;

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (bound_o == $past(load_val_i)) && !sat_o); // R2
   AST_NO_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_i) |=> bound_o >= $past(bound_o)); // R3
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_i) |=> $stable(bound_o) && $stable(sat_o)); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_o && !load_i) |=> sat_o); // R5
   AST_SAT_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sat_o) |-> bound_o == BND_MAX); // R5
endmodule

// File: rtl/acc_snap_reg.sv
module acc_snap_reg #(
   parameter int ACC_W  = 24,
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              snap_i,
   input  logic [TIME_W-1:0] time_i,
   input  logic [ACC_W-1:0]  neg_i,
   input  logic [ACC_W-1:0]  pos_i,
   output logic              valid_o,
   output logic [TIME_W-1:0] time_o,
   output logic [ACC_W-1:0]  neg_o,
   output logic [ACC_W-1:0]  pos_o
);
   logic              vld_q;
   logic [TIME_W-1:0] tim_q;
   logic [ACC_W-1:0]  neg_q, pos_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         tim_q <= '0;
         neg_q <= '0;
         pos_q <= '0;
      end else begin
         vld_q <= snap_i;
         if (snap_i) begin
            tim_q <= time_i;
            neg_q <= neg_i;
            pos_q <= pos_i;
         end
      end
   end

   assign valid_o = vld_q;
   assign time_o  = tim_q;
   assign neg_o   = neg_q;
   assign pos_o   = pos_q;

   AST_SNAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_i |=> $stable(time_o) && $stable(neg_o) && $stable(pos_o)); // R8
endmodule

// File: rtl/acc_interval_unit.sv
module acc_interval_unit #(
   parameter int ACC_W  = 24,
   parameter int STEP_W = 12,
   parameter int TIME_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              load_neg_i,
   input  logic              load_pos_i,
   input  logic [ACC_W-1:0]  load_val_i,
   input  logic              step_neg_wr_i,
   input  logic              step_pos_wr_i,
   input  logic [STEP_W-1:0] step_val_i,
   input  logic              snap_i,
   input  logic [TIME_W-1:0] time_i,
   output logic [ACC_W-1:0]  neg_bound_o,
   output logic [ACC_W-1:0]  pos_bound_o,
   output logic              neg_sat_o,
   output logic              pos_sat_o,
   output logic              snap_valid_o,
   output logic [TIME_W-1:0] snap_time_o,
   output logic [ACC_W-1:0]  snap_neg_o,
   output logic [ACC_W-1:0]  snap_pos_o
);
   import acc_pkg::*;

   localparam int NB = NUM_BOUNDS;

   initial begin
      assert (STEP_W >= 1 && STEP_W <= ACC_W)
         else $error("increment width must be between 1 and the bound width");
      assert (ACC_W >= 2 && TIME_W >= 1)
         else $error("bound or time width too small");
   end

   logic [NB-1:0]             load_v, stwr_v, sat_v;
   logic [NB-1:0][STEP_W-1:0] step_v;
   logic [NB-1:0][ACC_W-1:0]  bnd_v;

   assign load_v[BND_NEG] = load_neg_i;
   assign load_v[BND_POS] = load_pos_i;
   assign stwr_v[BND_NEG] = step_neg_wr_i;
   assign stwr_v[BND_POS] = step_pos_wr_i;

   for (genvar g = 0; g < NB; g++) begin : g_bound
      acc_step_reg #(.STEP_W(STEP_W)) u_step (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_i   (stwr_v[g]),
         .val_i  (step_val_i),
         .step_o (step_v[g])
      );

      acc_bound_adder #(.ACC_W(ACC_W), .STEP_W(STEP_W)) u_add (
         .clk        (clk),
         .rst_n      (rst_n),
         .tick_i     (tick_i),
         .load_i     (load_v[g]),
         .load_val_i (load_val_i),
         .step_i     (step_v[g]),
         .bound_o    (bnd_v[g]),
         .sat_o      (sat_v[g])
      );
   end

   acc_snap_reg #(.ACC_W(ACC_W), .TIME_W(TIME_W)) u_snap (
      .clk     (clk),
      .rst_n   (rst_n),
      .snap_i  (snap_i),
      .time_i  (time_i),
      .neg_i   (bnd_v[BND_NEG]),
      .pos_i   (bnd_v[BND_POS]),
      .valid_o (snap_valid_o),
      .time_o  (snap_time_o),
      .neg_o   (snap_neg_o),
      .pos_o   (snap_pos_o)
   );

   assign neg_bound_o = bnd_v[BND_NEG];
   assign pos_bound_o = bnd_v[BND_POS];
   assign neg_sat_o   = sat_v[BND_NEG];
   assign pos_sat_o   = sat_v[BND_POS];

   AST_SNAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      snap_i |=> snap_valid_o); // R8
   AST_SNAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_i |=> !snap_valid_o); // R8
   AST_SNAP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      snap_i |=> (snap_neg_o == $past(neg_bound_o)) && (snap_pos_o == $past(pos_bound_o))); // R8
   AST_NEG_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_pos_i) |=> $stable(pos_bound_o)); // R4
   AST_POS_ALONE: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load_neg_i) |=> $stable(neg_bound_o)); // R4
endmodule

// File: tb/acc_interval_unit_tb.sv
`timescale 1ns/1ps
module acc_interval_unit_tb_top;
   localparam int AW = 24;
   localparam int SW = 12;
   localparam int TW = 32;
   localparam logic [AW-1:0] MAXV = {AW{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_i = 0, load_neg_i = 0, load_pos_i = 0;
   logic [AW-1:0] load_val_i = '0;
   logic          step_neg_wr_i = 0, step_pos_wr_i = 0;
   logic [SW-1:0] step_val_i = '0;
   logic          snap_i = 0;
   logic [TW-1:0] time_i = '0;
   logic [AW-1:0] neg_bound_o, pos_bound_o, snap_neg_o, snap_pos_o;
   logic          neg_sat_o, pos_sat_o, snap_valid_o;
   logic [TW-1:0] snap_time_o;

   always #2.5 clk = ~clk;

   acc_interval_unit #(.ACC_W(AW), .STEP_W(SW), .TIME_W(TW)) dut_i (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .load_neg_i(load_neg_i), .load_pos_i(load_pos_i), .load_val_i(load_val_i),
      .step_neg_wr_i(step_neg_wr_i), .step_pos_wr_i(step_pos_wr_i), .step_val_i(step_val_i),
      .snap_i(snap_i), .time_i(time_i),
      .neg_bound_o(neg_bound_o), .pos_bound_o(pos_bound_o),
      .neg_sat_o(neg_sat_o), .pos_sat_o(pos_sat_o),
      .snap_valid_o(snap_valid_o), .snap_time_o(snap_time_o),
      .snap_neg_o(snap_neg_o), .snap_pos_o(snap_pos_o)
   );

   typedef struct packed {
      logic [AW-1:0] neg;
      logic [AW-1:0] pos;
      logic          fn;
      logic          fp;
      logic          sv;
      logic [TW-1:0] st;
      logic [AW-1:0] sn;
      logic [AW-1:0] sp;
   } exp_t;

   exp_t  exp_q[$];
   string tag_q[$];
   int    n_checks = 0;
   int    n_errors = 0;

   // reference state built from the requirements
   logic [AW-1:0] m_neg = MAXV, m_pos = MAXV, m_sn = '0, m_sp = '0;
   logic          m_fn = 1'b1, m_fp = 1'b1, m_sv = 1'b0;
   logic [SW-1:0] m_stn = '0, m_stp = '0;
   logic [TW-1:0] m_st = '0;

   function automatic logic [AW:0] widen(input logic [AW-1:0] b, input logic [SW-1:0] s);
      return {1'b0, b} + {{(AW+1-SW){1'b0}}, s};
   endfunction

   task automatic cyc(input logic ln, input logic lp, input logic [AW-1:0] lv,
                      input logic wn, input logic wp, input logic [SW-1:0] sv,
                      input logic tk, input logic sn, input logic [TW-1:0] tm,
                      input string tag);
      exp_t e;
      logic [AW:0] sum_n, sum_p;
      @(negedge clk);
      load_neg_i = ln; load_pos_i = lp; load_val_i = lv;
      step_neg_wr_i = wn; step_pos_wr_i = wp; step_val_i = sv;
      tick_i = tk; snap_i = sn; time_i = tm;
      sum_n = widen(m_neg, m_stn);
      sum_p = widen(m_pos, m_stp);
      if (sn) begin
         m_st = tm; m_sn = m_neg; m_sp = m_pos;
      end
      m_sv = sn;
      if (ln) begin m_neg = lv; m_fn = 1'b0; end
      else if (tk) begin
         if (sum_n[AW]) begin m_neg = MAXV; m_fn = 1'b1; end
         else m_neg = sum_n[AW-1:0];
      end
      if (lp) begin m_pos = lv; m_fp = 1'b0; end
      else if (tk) begin
         if (sum_p[AW]) begin m_pos = MAXV; m_fp = 1'b1; end
         else m_pos = sum_p[AW-1:0];
      end
      if (wn) m_stn = sv;
      if (wp) m_stp = sv;
      e = '{neg: m_neg, pos: m_pos, fn: m_fn, fp: m_fp, sv: m_sv,
            st: m_st, sn: m_sn, sp: m_sp};
      exp_q.push_back(e);
      tag_q.push_back(tag);
   endtask

   task automatic idle(input string tag);
      cyc(0, 0, '0, 0, 0, '0, 0, 0, '0, tag);
   endtask
   task automatic tick(input string tag);
      cyc(0, 0, '0, 0, 0, '0, 1, 0, '0, tag);
   endtask

   // monitor: compare after each rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            exp_t  e;
            exp_t  a;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            a = '{neg: neg_bound_o, pos: pos_bound_o, fn: neg_sat_o, fp: pos_sat_o,
                  sv: snap_valid_o, st: snap_time_o, sn: snap_neg_o, sp: snap_pos_o};
            n_checks++;
            if (a !== e) begin
               n_errors++;
               $display("FAIL %s: actual neg=%0h pos=%0h fn=%0b fp=%0b sv=%0b st=%0h sn=%0h sp=%0h expected neg=%0h pos=%0h fn=%0b fp=%0b sv=%0b st=%0h sn=%0h sp=%0h",
                        t, a.neg, a.pos, a.fn, a.fp, a.sv, a.st, a.sn, a.sp,
                        e.neg, e.pos, e.fn, e.fp, e.sv, e.st, e.sn, e.sp);
            end
         end
      end
   end

   initial begin
      #(5.0 * 150000);
      n_errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #0.5;
      // R1 reset state
      n_checks++;
      if (neg_bound_o !== MAXV || pos_bound_o !== MAXV || neg_sat_o !== 1'b1 ||
          pos_sat_o !== 1'b1 || snap_valid_o !== 1'b0 || snap_time_o !== '0 ||
          snap_neg_o !== '0 || snap_pos_o !== '0) begin
         n_errors++;
         $display("FAIL R1: actual neg=%0h pos=%0h fn=%0b fp=%0b sv=%0b expected neg=%0h pos=%0h fn=1 fp=1 sv=0",
                  neg_bound_o, pos_bound_o, neg_sat_o, pos_sat_o, snap_valid_o, MAXV, MAXV);
      end
      // R1 zero increments: tick at reset saturates, flags stay set
      tick("R1");
      // R6 increments
      cyc(0, 0, '0, 1, 0, 12'd5, 0, 0, '0, "R6");
      cyc(0, 0, '0, 0, 1, 12'd9, 0, 0, '0, "R6");
      // R2 load both
      cyc(1, 1, 24'd100, 0, 0, '0, 0, 0, '0, "R2");
      cyc(0, 1, 24'd200, 0, 0, '0, 0, 0, '0, "R4");
      // R3 ticks with different increments
      tick("R3");
      tick("R3");
      tick("R4");
      idle("R7");
      idle("R7");
      // R6 write during tick uses old increment
      cyc(0, 0, '0, 1, 0, 12'd1, 1, 0, '0, "R6");
      tick("R6");
      // R2 load overrides tick
      cyc(1, 0, 24'd50, 0, 0, '0, 1, 0, '0, "R2");
      // R8 snapshot during tick, then hold
      cyc(0, 0, '0, 0, 0, '0, 1, 1, 32'hCAFE_0123, "R8");
      idle("R8");
      tick("R8");
      cyc(0, 0, '0, 0, 0, '0, 0, 1, 32'h0000_0777, "R8");
      // R5 exact landing on max keeps flag clear
      cyc(1, 0, MAXV - 24'd10, 1, 0, 12'd10, 0, 0, '0, "R5");
      cyc(0, 1, MAXV - 24'd3, 0, 0, '0, 0, 0, '0, "R5");
      tick("R5");
      tick("R5");
      tick("R5");
      idle("R5");
      cyc(0, 0, '0, 0, 0, '0, 0, 1, 32'h1234_5678, "R8");
      // R5 load clears flag; R4 the other bound stays saturated
      cyc(1, 0, 24'd7, 0, 0, '0, 0, 0, '0, "R5");
      tick("R4");
      cyc(0, 1, 24'd0, 0, 1, 12'hFFF, 1, 0, '0, "R2");
      tick("R3");
      tick("R3");
      idle("R7");
      @(negedge clk);
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end
endmodule